// File: doc/BRIEF.md
# Hashed Page Table Walker

This block translates one effective address through a hashed page table held in memory. The segment that covers the address has already been found elsewhere. The caller supplies that segment's virtual segment identifier, a 1 TB segment flag and a large-page flag. The walker hashes the page number within the segment and reads the eight entries of one group in ascending order. If none of them matches, it reads the eight entries of the group picked by the complemented hash. On a hit it returns the entry and its offset in the table, and forms the real address. It also sets the referenced bit, sets the changed bit for stores, and writes the second entry word back only when its value changed.

When relocation is off for the access type, the walker makes no memory access. It returns the effective address with its four top bits cleared, and grants full access. On a miss it reports a fault syndrome and, for data accesses, the faulting address. Permission decoding and segment lookup stay outside the block, so every hit counts as granted. A hit on any access other than a store is granted without write permission, so the first store to that page comes back through the walker and marks the page changed.

Top module: `hpt_walker`

## Requirements
- R1: The page size comes from `seg_large`: 16 MB pages (24 page bits) when it is set, 4 KB pages (12 page bits) otherwise. The page number is the offset within the segment shifted right by the page bits. The offset is address bits 27:0 for a 256 MB segment and bits 39:0 for a 1 TB segment.
- R2: The hash is VSID XOR page number for a 256 MB segment. For a 1 TB segment it is VSID XOR (VSID shifted left by 25) XOR page number. The VSID is zero-extended to 64 bits.
- R3: The first pass reads the group at `tbl_base + ((hash << 7) & tbl_mask)`. The second pass uses the bitwise complement of the hash in place of the hash.
- R4: Entry i of a group is one 128-bit read at group address + 16*i. Word 0 is `mem_rdata[63:0]` and word 1 is `mem_rdata[127:64]`. An entry matches only if all three of these hold:
  - word 0 bit 0 (valid) is set;
  - word 0 bit 1 equals the pass number (0 for the first pass, 1 for the second);
  - word 0 bits 63:7 equal {1 TB flag, VSID[49:0], effective offset bits 28:23}.
- R5: A group holds 8 entries. They are read in ascending order, the first match ends the walk, and the second pass runs only when the first pass finds nothing.
- R6: When both passes miss, `hit` is 0 and the walk reads 16 entries. A fetch reports code 0x40000000 and `fault_addr` 0. A load reports 0x40000000 and a store reports 0x42000000, both with `fault_addr` equal to the effective address.
- R7: On a hit, word 1 has bit 8 (referenced) set, and also bit 7 (changed) for a store. The new word 1 is written to entry address + 8 only if it differs from the word read. `pte_w1` reports the new word.
- R8: A translated hit grants write permission (`wr_ok`) only for a store (`acc_kind` 1). Loads (0) and fetches (2) are granted without it.
- R9: On a hit the real address is word 1 with its low page-size bits cleared, ORed with the low page-size bits of the effective address. `pte_off` is the entry's offset from `tbl_base`.
- R10: Relocation is off when `xlate_i` is 0 for a fetch, or when `xlate_d` is 0 for any other access. In that case the walker makes no memory access. It returns `hit` 1, `wr_ok` 1 and the real address equal to the effective address with bits 63:60 cleared.
- R11: A request holds `mem_valid`, `mem_we` and `mem_addr` stable until `mem_ready` is sampled high. `done` is a single-cycle pulse. After reset `done` and `mem_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk; inputs sampled this cycle |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch |
| xlate_i | input | 1 | Instruction relocation enable |
| xlate_d | input | 1 | Data relocation enable |
| ea | input | 64 | Effective address |
| seg_vsid | input | 50 | Virtual segment identifier of the hitting segment |
| seg_1t | input | 1 | Segment is 1 TB (else 256 MB) |
| seg_large | input | 1 | Segment uses 16 MB pages |
| tbl_base | input | 64 | Table base address |
| tbl_mask | input | 64 | Table offset mask |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Request byte address |
| mem_wdata | output | 64 | Write data (entry word 1) |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 128 | Read data, one whole entry |
| done | output | 1 | Walk finished (one cycle) |
| hit | output | 1 | Translation found or relocation off |
| real_addr | output | 64 | Real address |
| wr_ok | output | 1 | Write permission granted |
| pte_w0 | output | 64 | Matched entry word 0 |
| pte_w1 | output | 64 | Matched entry word 1 after update |
| pte_off | output | 64 | Matched entry offset in the table |
| fault_code | output | 32 | Miss syndrome |
| fault_addr | output | 64 | Captured faulting address |

## Verification
Walks are tried with decoy entries placed ahead of the real match: one with the valid bit clear, one with the wrong pass bit and one with a compare field off by one bit. The count of reads shows whether each decoy was rejected, and two true matches in one group show which one wins. A match placed only in the secondary group, behind an entry in the primary group whose pass bit is set, separates the two passes and the complemented hash. Both segment sizes and both page sizes are used, so that different groups and real addresses result. Loads, stores and fetches are run against entries whose referenced and changed bits start clear or already set, which tells the lazy changed bit and the skipped write-back apart. Relocation-off cases use each access type with only the matching relocation enable cleared.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_WAIT = 3'd2,
        ST_WB   = 3'd3,
        ST_FIN  = 3'd4
    } walk_st_e;

    localparam logic [31:0] CODE_NOT_FOUND = 32'h4000_0000;
    localparam logic [31:0] CODE_IS_STORE  = 32'h0200_0000;

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
    parameter int AW        = 64,
    parameter int VSID_W    = 50,
    parameter int SMALL_PG  = 12,
    parameter int LARGE_PG  = 24,
    parameter int SEG_SMALL = 28,
    parameter int SEG_LARGE = 40,
    parameter int XOR_SHIFT = 25,
    parameter int GRP_SHIFT = 7,
    parameter int CMP_LO    = 7,
    parameter int AVPN_LO   = 23
) (
    input  logic [AW-1:0]         ea,
    input  logic [VSID_W-1:0]     vsid,
    input  logic                  seg_1t,
    input  logic                  seg_large,
    input  logic [AW-1:0]         tbl_mask,
    output logic [AW-1:0]         grp_pri,
    output logic [AW-1:0]         grp_sec,
    output logic [AW-CMP_LO-1:0]  cmp_val,
    output logic [AW-1:0]         pg_mask
);
    localparam int CMP_W = AW - CMP_LO;
    localparam int PN_W  = CMP_W - 1 - VSID_W;
    localparam logic [AW-1:0] SEGM_S = {{(AW-SEG_SMALL){1'b0}}, {SEG_SMALL{1'b1}}};
    localparam logic [AW-1:0] SEGM_L = {{(AW-SEG_LARGE){1'b0}}, {SEG_LARGE{1'b1}}};
    localparam logic [AW-1:0] PGM_S  = {{(AW-SMALL_PG){1'b0}}, {SMALL_PG{1'b1}}};
    localparam logic [AW-1:0] PGM_L  = {{(AW-LARGE_PG){1'b0}}, {LARGE_PG{1'b1}}};

    logic [AW-1:0] seg_off;
    logic [AW-1:0] pn;
    logic [AW-1:0] vs;
    logic [AW-1:0] hash;

    always_comb begin
        seg_off = ea & (seg_1t ? SEGM_L : SEGM_S);
        pg_mask = seg_large ? PGM_L : PGM_S;
        pn      = seg_large ? (seg_off >> LARGE_PG) : (seg_off >> SMALL_PG);
        vs      = AW'(vsid);
        // R2: the 1 TB form folds in a shifted copy of the VSID
        hash    = vs ^ pn ^ (seg_1t ? (vs << XOR_SHIFT) : '0);
        // R3: primary and complemented group offsets
        grp_pri = (hash << GRP_SHIFT) & tbl_mask;
        grp_sec = ((~hash) << GRP_SHIFT) & tbl_mask;
        // R4: compare value
        cmp_val = {seg_1t, vsid, seg_off[AVPN_LO +: PN_W]};
    end
endmodule

// File: rtl/hpt_entry_chk.sv
module hpt_entry_chk #(
    parameter int AW      = 64,
    parameter int CMP_LO  = 7,
    parameter int VLD_BIT = 0,
    parameter int SEC_BIT = 1,
    parameter int REF_BIT = 8,
    parameter int CHG_BIT = 7
) (
    input  logic [AW-1:0]         w0,
    input  logic [AW-1:0]         w1,
    input  logic [AW-CMP_LO-1:0]  cmp_val,
    input  logic                  pass,
    input  logic                  is_store,
    input  logic [AW-1:0]         ea,
    input  logic [AW-1:0]         pg_mask,
    output logic                  match,
    output logic [AW-1:0]         w1_new,
    output logic                  need_wb,
    output logic [AW-1:0]         ra
);
    localparam logic [AW-1:0] CMP_MASK = {{(AW-CMP_LO){1'b1}}, {CMP_LO{1'b0}}};
    localparam logic [AW-1:0] REF_M    = AW'(1) << REF_BIT;
    localparam logic [AW-1:0] CHG_M    = AW'(1) << CHG_BIT;

    logic cmp_eq;

    always_comb begin
        cmp_eq  = ((w0 ^ {cmp_val, {CMP_LO{1'b0}}}) & CMP_MASK) == '0;
        // R4: valid, pass bit and compare field
        match   = w0[VLD_BIT] && (w0[SEC_BIT] == pass) && cmp_eq;
        // R7: referenced always, changed only for stores
        w1_new  = w1 | REF_M | (is_store ? CHG_M : '0);
        need_wb = (w1_new != w1);
        // R9: page frame from the entry, page offset from the address
        ra      = (w1 & ~pg_mask) | (ea & pg_mask);
    end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int AW         = 64,
    parameter int VSID_W     = 50,
    parameter int GRP_ENT    = 8,
    parameter int ENT_BYTES  = 16,
    parameter int REAL_TOP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        acc_kind,
    input  logic              xlate_i,
    input  logic              xlate_d,
    input  logic [AW-1:0]     ea,
    input  logic [VSID_W-1:0] seg_vsid,
    input  logic              seg_1t,
    input  logic              seg_large,
    input  logic [AW-1:0]     tbl_base,
    input  logic [AW-1:0]     tbl_mask,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [AW-1:0]     mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [2*AW-1:0]   mem_rdata,
    output logic              done,
    output logic              hit,
    output logic [AW-1:0]     real_addr,
    output logic              wr_ok,
    output logic [AW-1:0]     pte_w0,
    output logic [AW-1:0]     pte_w1,
    output logic [AW-1:0]     pte_off,
    output logic [31:0]       fault_code,
    output logic [AW-1:0]     fault_addr
);
    localparam int IDX_W     = $clog2(GRP_ENT);
    localparam int ENT_SHIFT = $clog2(ENT_BYTES);
    localparam int GRP_SHIFT = $clog2(GRP_ENT * ENT_BYTES);
    localparam int CMP_LO    = 7;
    localparam int CMP_W     = AW - CMP_LO;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GRP_ENT - 1);
    localparam logic [AW-1:0] W1_OFF   = AW'(AW / 8);
    localparam logic [AW-1:0] REAL_MSK = {{REAL_TOP{1'b0}}, {(AW-REAL_TOP){1'b1}}};

    typedef struct packed {
        walk_st_e          st;
        logic [1:0]        kind;
        logic [AW-1:0]     ea;
        logic [VSID_W-1:0] vsid;
        logic              s1t;
        logic              slg;
        logic [AW-1:0]     base;
        logic [AW-1:0]     mask;
        logic              pass;
        logic [IDX_W-1:0]  idx;
        logic              bypass;
        logic              hit;
        logic              wr_ok;
        logic [AW-1:0]     ra;
        logic [AW-1:0]     off;
        logic [AW-1:0]     faddr;
        logic [AW-1:0]     w0;
        logic [AW-1:0]     w1;
        logic [31:0]       code;
    } regs_t;

    regs_t r_d, r_q;

    logic [AW-1:0]    grp_pri, grp_sec, pg_mask, grp_cur, ent_off;
    logic [CMP_W-1:0] cmp_val;
    logic             match, need_wb, is_store, bypass_now;
    logic [AW-1:0]    w1_new, ra_c, word0, word1;

    hpt_hash #(
        .AW(AW), .VSID_W(VSID_W), .GRP_SHIFT(GRP_SHIFT), .CMP_LO(CMP_LO)
    ) hash_i (
        .ea(r_q.ea), .vsid(r_q.vsid), .seg_1t(r_q.s1t), .seg_large(r_q.slg),
        .tbl_mask(r_q.mask), .grp_pri(grp_pri), .grp_sec(grp_sec),
        .cmp_val(cmp_val), .pg_mask(pg_mask)
    );

    assign word0    = mem_rdata[AW-1:0];
    assign word1    = mem_rdata[2*AW-1:AW];
    assign is_store = (r_q.kind == ACC_STORE);

    hpt_entry_chk #(.AW(AW), .CMP_LO(CMP_LO)) chk_i (
        .w0(word0), .w1(word1), .cmp_val(cmp_val), .pass(r_q.pass),
        .is_store(is_store), .ea(r_q.ea), .pg_mask(pg_mask),
        .match(match), .w1_new(w1_new), .need_wb(need_wb), .ra(ra_c)
    );

    always_comb begin
        r_d        = r_q;
        grp_cur    = r_q.pass ? grp_sec : grp_pri;
        ent_off    = grp_cur + {{(AW-IDX_W-ENT_SHIFT){1'b0}}, r_q.idx, {ENT_SHIFT{1'b0}}};
        bypass_now = (acc_kind == ACC_FETCH) ? !xlate_i : !xlate_d;

        mem_valid  = (r_q.st == ST_REQ) || (r_q.st == ST_WB);
        mem_we     = (r_q.st == ST_WB);
        mem_addr   = r_q.base + ((r_q.st == ST_WB) ? (r_q.off + W1_OFF) : ent_off);
        mem_wdata  = r_q.w1;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.kind   = acc_kind;
                    r_d.ea     = ea;
                    r_d.vsid   = seg_vsid;
                    r_d.s1t    = seg_1t;
                    r_d.slg    = seg_large;
                    r_d.base   = tbl_base;
                    r_d.mask   = tbl_mask;
                    r_d.pass   = 1'b0;
                    r_d.idx    = '0;
                    r_d.bypass = bypass_now;
                    if (bypass_now) begin
                        // R10: relocation off
                        r_d.hit   = 1'b1;
                        r_d.wr_ok = 1'b1;
                        r_d.ra    = ea & REAL_MSK;
                        r_d.off   = '0;
                        r_d.w0    = '0;
                        r_d.w1    = '0;
                        r_d.code  = '0;
                        r_d.faddr = '0;
                        r_d.st    = ST_FIN;
                    end else begin
                        r_d.st    = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (mem_ready) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rvalid) begin
                    if (match) begin
                        r_d.hit   = 1'b1;
                        r_d.wr_ok = is_store;          // R8
                        r_d.ra    = ra_c;
                        r_d.off   = ent_off;
                        r_d.w0    = word0;
                        r_d.w1    = w1_new;
                        r_d.code  = '0;
                        r_d.faddr = '0;
                        r_d.st    = need_wb ? ST_WB : ST_FIN;
                    end else if (r_q.idx != LAST_IDX) begin
                        r_d.idx   = r_q.idx + 1'b1;
                        r_d.st    = ST_REQ;
                    end else if (!r_q.pass) begin
                        r_d.pass  = 1'b1;              // R5: second pass
                        r_d.idx   = '0;
                        r_d.st    = ST_REQ;
                    end else begin
                        // R6: both passes missed
                        r_d.hit   = 1'b0;
                        r_d.wr_ok = 1'b0;
                        r_d.ra    = '0;
                        r_d.off   = '0;
                        r_d.w0    = '0;
                        r_d.w1    = '0;
                        r_d.code  = is_store ? (CODE_NOT_FOUND | CODE_IS_STORE) : CODE_NOT_FOUND;
                        r_d.faddr = (r_q.kind == ACC_FETCH) ? '0 : r_q.ea;
                        r_d.st    = ST_FIN;
                    end
                end
            end
            ST_WB: begin
                if (mem_ready) r_d.st = ST_FIN;
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done       = (r_q.st == ST_FIN);
    assign hit        = r_q.hit;
    assign real_addr  = r_q.ra;
    assign wr_ok      = r_q.wr_ok;
    assign pte_w0     = r_q.w0;
    assign pte_w1     = r_q.w1;
    assign pte_off    = r_q.off;
    assign fault_code = r_q.code;
    assign fault_addr = r_q.faddr;

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    wb_ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> (mem_wdata[8] && (mem_addr[ENT_SHIFT-1:0] == ENT_SHIFT'(W1_OFF))));

    // R8
    wr_ok_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wr_ok) |-> (r_q.bypass || (r_q.kind == ACC_STORE)));

    // R6
    miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (fault_code[30] && !r_q.bypass));

    // R10
    bypass_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_q.bypass) |-> (hit && real_addr[AW-1 -: REAL_TOP] == '0));
endmodule

// File: tb/hpt_walker_tb_top.sv
module hpt_walker_tb_top;
    localparam logic [63:0] BASE = 64'h0010_0000;
    localparam logic [63:0] MASK = 64'h0000_3F80;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   acc_kind = 2'd0;
    logic         xlate_i = 1'b1, xlate_d = 1'b1;
    logic [63:0]  ea = '0;
    logic [49:0]  seg_vsid = '0;
    logic         seg_1t = 1'b0, seg_large = 1'b0;
    logic         mem_valid, mem_we, mem_ready = 1'b0, mem_rvalid = 1'b0;
    logic [63:0]  mem_addr, mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic         done, hit, wr_ok;
    logic [63:0]  real_addr, pte_w0, pte_w1, pte_off, fault_addr;
    logic [31:0]  fault_code;

    always #10 clk = ~clk;

    hpt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .acc_kind(acc_kind),
        .xlate_i(xlate_i), .xlate_d(xlate_d), .ea(ea), .seg_vsid(seg_vsid),
        .seg_1t(seg_1t), .seg_large(seg_large), .tbl_base(BASE), .tbl_mask(MASK),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .hit(hit), .real_addr(real_addr),
        .wr_ok(wr_ok), .pte_w0(pte_w0), .pte_w1(pte_w1), .pte_off(pte_off),
        .fault_code(fault_code), .fault_addr(fault_addr)
    );

    int vectors = 0, miscompares = 0;

    // ---------------- memory model ----------------
    logic [127:0] mem_m [logic [63:0]];
    int nrd = 0, nwr = 0, cyc = 0, lat = 0;
    logic [63:0] rd_addr = '0;

    function automatic logic [127:0] rd_ent(input logic [63:0] a);
        if (mem_m.exists(a)) return mem_m[a];
        return '0;
    endfunction

    always @(posedge clk) begin
        cyc++;
        mem_ready  <= (cyc % 4) != 2;
        mem_rvalid <= 1'b0;
        if (lat == 1) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= rd_ent(rd_addr);
        end
        if (lat != 0) lat <= lat - 1;
        if (rst_n && mem_valid && mem_ready) begin
            if (mem_we) begin
                logic [63:0] a;
                logic [127:0] e;
                a = mem_addr & ~64'hF;
                e = rd_ent(a);
                e[127:64] = mem_wdata;
                mem_m[a] = e;
                nwr++;
            end else begin
                rd_addr <= mem_addr;
                lat     <= 1 + (nrd % 3);
                nrd++;
            end
        end
    end

    // ---------------- reference from the requirements ----------------
    logic [63:0] cur_ea;
    logic [49:0] cur_vsid;
    logic        cur_1t, cur_lg;

    function automatic logic [63:0] seg_off_f();
        return cur_1t ? (cur_ea & 64'h00FF_FFFF_FFFF) : (cur_ea & 64'h0FFF_FFFF);
    endfunction

    function automatic logic [63:0] grp_f(input logic p);
        logic [63:0] v, pn, h;
        v  = {14'b0, cur_vsid};
        pn = seg_off_f() >> (cur_lg ? 24 : 12);
        h  = cur_1t ? (v ^ (v << 25) ^ pn) : (v ^ pn);
        if (p) h = ~h;
        return (h << 7) & MASK;
    endfunction

    function automatic logic [63:0] mkw0(input logic sec, input logic vld);
        logic [63:0] so;
        so = seg_off_f();
        return {cur_1t, cur_vsid, so[28:23], 5'b0, sec, vld};
    endfunction

    task automatic place(input logic p, input int i, input logic [63:0] w0, input logic [63:0] w1);
        mem_m[BASE + grp_f(p) + 64'(i * 16)] = {w1, w0};
    endtask

    typedef struct {
        string       tag;
        logic        hit, wr_ok, xoff;
        logic [63:0] ra, w0, w1, off, faddr;
        logic [31:0] code;
        int          nrd, nwr, rd0, wr0;
    } exp_t;

    exp_t sbq[$];

    function automatic exp_t ref_walk(input logic [1:0] k, input logic ir, input logic dr);
        exp_t e;
        logic [63:0] pm;
        e.hit = 0; e.wr_ok = 0; e.xoff = 0; e.ra = 0; e.w0 = 0; e.w1 = 0;
        e.off = 0; e.faddr = 0; e.code = 0; e.nrd = 0; e.nwr = 0;
        if ((k == 2'd2) ? !ir : !dr) begin
            e.xoff = 1; e.hit = 1; e.wr_ok = 1;
            e.ra = {4'b0, cur_ea[59:0]};
            return e;
        end
        pm = cur_lg ? 64'hFF_FFFF : 64'hFFF;
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 8; i++) begin
                logic [63:0] o;
                logic [127:0] ent;
                o   = grp_f(p[0]) + 64'(i * 16);
                ent = rd_ent(BASE + o);
                e.nrd++;
                if (ent[0] && ent[1] == p[0] && ent[63:7] == mkw0(p[0], 1'b1) >> 7) begin
                    e.hit = 1;
                    e.wr_ok = (k == 2'd1);
                    e.w0 = ent[63:0];
                    e.w1 = ent[127:64] | 64'h100 | ((k == 2'd1) ? 64'h80 : 64'h0);
                    e.nwr = (e.w1 != ent[127:64]) ? 1 : 0;
                    e.off = o;
                    e.ra = (ent[127:64] & ~pm) | (cur_ea & pm);
                    return e;
                end
            end
        end
        e.code  = (k == 2'd1) ? 32'h4200_0000 : 32'h4000_0000;
        e.faddr = (k == 2'd2) ? 64'h0 : cur_ea;
        return e;
    endfunction

    // ---------------- checking ----------------
    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] expv);
        vectors++;
        if (act !== expv) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                chk("R11", "unexpected done", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(e.tag, "hit", 64'(hit), 64'(e.hit));
                chk(e.tag, "real_addr", real_addr, e.ra);
                chk(e.tag, "wr_ok", 64'(wr_ok), 64'(e.wr_ok));
                chk(e.tag, "pte_w0", pte_w0, e.w0);
                chk(e.tag, "pte_w1", pte_w1, e.w1);
                chk(e.tag, "pte_off", pte_off, e.off);
                chk(e.tag, "fault_code", 64'(fault_code), 64'(e.code));
                chk(e.tag, "fault_addr", fault_addr, e.faddr);
                chk(e.tag, "reads", 64'(nrd - e.rd0), 64'(e.nrd));
                chk(e.tag, "writes", 64'(nwr - e.wr0), 64'(e.nwr));
                if (e.hit && !e.xoff) begin
                    logic [127:0] m;
                    m = rd_ent(BASE + e.off);
                    chk(e.tag, "stored word1", m[127:64], e.w1);
                end
            end
        end
    end

    task automatic seg(input logic [63:0] a, input logic [49:0] v, input logic t, input logic l);
        mem_m.delete();
        cur_ea = a; cur_vsid = v; cur_1t = t; cur_lg = l;
    endtask

    task automatic walk(input string tag, input logic [1:0] k, input logic ir, input logic dr);
        exp_t e;
        e = ref_walk(k, ir, dr);
        e.tag = tag; e.rd0 = nrd; e.wr0 = nwr;
        sbq.push_back(e);
        @(negedge clk);
        acc_kind = k; xlate_i = ir; xlate_d = dr; ea = cur_ea;
        seg_vsid = cur_vsid; seg_1t = cur_1t; seg_large = cur_lg;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (sbq.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R11: reset state
        chk("R11", "done after reset", 64'(done), 64'd0);
        chk("R11", "mem_valid after reset", 64'(mem_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R9: 256 MB segment, 4 KB page, load hit at entry 0
        seg(64'h0000_0005_0ABC_D123, 50'h1234, 1'b0, 1'b0);
        place(0, 0, mkw0(0, 1), 64'h0000_0000_7777_7000);
        walk("R9", 2'd0, 1'b1, 1'b1);
        chk("R9", "real address literal", real_addr, 64'h7777_7123);

        // R2 R4: 1 TB segment, decoys before the match at entry 3
        seg(64'h0000_00AB_CDE4_5678, 50'h2_ABCD_1357, 1'b1, 1'b0);
        place(0, 0, mkw0(0, 0), 64'h1111_1000);
        place(0, 1, mkw0(1, 1), 64'h2222_2000);
        place(0, 2, mkw0(0, 1) ^ 64'h80, 64'h3333_3000);
        place(0, 3, mkw0(0, 1), 64'h4444_4000);
        walk("R4", 2'd0, 1'b1, 1'b1);

        // R5: two matches, the lower index wins
        seg(64'h0000_0000_0123_4567, 50'h0F0F, 1'b0, 1'b0);
        place(0, 2, mkw0(0, 1), 64'hAAAA_A000);
        place(0, 5, mkw0(0, 1), 64'hBBBB_B000);
        walk("R5", 2'd0, 1'b1, 1'b1);

        // R3: match only in the complemented group
        seg(64'h0000_0000_0765_4321, 50'h3_0000_0042, 1'b0, 1'b0);
        place(0, 0, mkw0(1, 1), 64'hCCCC_C000);
        place(1, 6, mkw0(1, 1), 64'hDDDD_D000);
        walk("R3", 2'd0, 1'b1, 1'b1);

        // R6: misses for each access type
        seg(64'h0000_0000_0FED_C000, 50'h777, 1'b0, 1'b0);
        walk("R6", 2'd0, 1'b1, 1'b1);
        walk("R6", 2'd1, 1'b1, 1'b1);
        walk("R6", 2'd2, 1'b1, 1'b1);

        // R7 R8: store sets R and C and grants write
        seg(64'h0000_0000_0246_8ACE, 50'h5A5, 1'b0, 1'b0);
        place(0, 1, mkw0(0, 1), 64'h1357_9000);
        walk("R7", 2'd1, 1'b1, 1'b1);
        // R7: second store finds R and C set, no write-back
        walk("R7", 2'd1, 1'b1, 1'b1);
        // R8: fetch hit grants no write permission
        walk("R8", 2'd2, 1'b1, 1'b1);

        // R7: load with R already set makes no write
        seg(64'h0000_0000_0135_7000, 50'h99, 1'b0, 1'b0);
        place(0, 4, mkw0(0, 1), 64'h0246_8100);
        walk("R7", 2'd0, 1'b1, 1'b1);

        // R1 R9: 16 MB page in a 1 TB segment
        seg(64'h0000_0012_3ABC_DEF0, 50'h1_2345, 1'b1, 1'b1);
        place(0, 7, mkw0(0, 1), 64'h0000_0003_4055_5000);
        walk("R1", 2'd0, 1'b1, 1'b1);
        chk("R1", "large page literal", real_addr, 64'h0000_0003_40BC_DEF0);

        // R10: relocation off for data, fetch and the mismatched enable
        seg(64'hF234_5678_9ABC_DEF0, 50'h1, 1'b0, 1'b0);
        walk("R10", 2'd1, 1'b1, 1'b0);
        walk("R10", 2'd2, 1'b0, 1'b1);
        walk("R10", 2'd0, 1'b0, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule